// File: doc/BRIEF.md
# Register-Pair Word Arithmetic Unit

This block performs 16-bit arithmetic for a processor core whose accumulator pair is formed from two byte registers. Y is the upper byte and A the lower. The second input is a 16-bit memory word. Five operations are offered: add a word to the pair, subtract a word from the pair, compare the pair with a word, and increment or decrement the memory word.

The work is split across two clock cycles on a byte-wide adder. The low byte is summed at the clock edge that accepts the start strobe. The high byte is summed at the following edge, using the low-byte carry. The result then appears with a one-cycle done pulse.

The unit also reports where the result goes: back into the pair, or back to memory. A five-bit write mask states which status flags the surrounding core should update. Instruction decode and memory sequencing sit outside this block.

Top module: `pair_word_alu`

## Requirements
- R1: After reset, busy, done, writeYa, writeMem, flagWe, result and all five flag outputs read zero.
- R2: A start strobe is accepted when the unit is idle and opSel is 0 to 4. Busy is high for exactly the next cycle. Done is high for exactly the one cycle after that. Result, flags, flagWe, writeYa and writeMem change only at the edge that raises done, and then hold.
- R3: A start strobe seen while busy is high is ignored. A start strobe with opSel 5, 6 or 7 is also ignored: busy and done stay low and all outputs keep their values.
- R4: opSel 0 (add) gives result = {regY,regA} + memWord modulo 2^16 and raises writeYa. C is the carry out of bit 15. flagWe is 5'b11111, where the flagWe bits from 4 down to 0 stand for N, V, H, Z, C.
- R5: opSel 1 (subtract) gives result = {regY,regA} - memWord modulo 2^16 and raises writeYa. It sets flagWe to 5'b11111. C is 1 exactly when {regY,regA} >= memWord, which includes a zero operand.
- R6: For add and subtract, V is 1 exactly when the signed 16-bit result of the operation lies outside -32768..32767.
- R7: For add, H is the carry out of bit 11 of {regY,regA} + memWord. For subtract, H is the carry out of bit 11 of {regY,regA} + ~memWord + 1, which is the carry from the fourth bit of the high-byte addition.
- R8: opSel 2 (compare) computes the same difference and C as subtract. It raises neither writeYa nor writeMem. flagWe is 5'b10011, so V and H are left untouched.
- R9: opSel 3 (increment) and opSel 4 (decrement) give result = memWord + 1 or memWord - 1 modulo 2^16. The low-byte carry or borrow reaches the high byte. writeMem is raised and flagWe is 5'b10010.
- R10: For every operation, N equals bit 15 of the result. Z is 1 only when all 16 result bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an operation |
| opSel | input | 3 | Operation: 0 add, 1 subtract, 2 compare, 3 increment, 4 decrement |
| regY | input | BYTE_W (8) | High byte of the register pair |
| regA | input | BYTE_W (8) | Low byte of the register pair |
| memWord | input | 2*BYTE_W (16) | Memory word operand |
| busy | output | 1 | High-byte cycle in progress |
| done | output | 1 | One-cycle pulse; outputs are valid |
| result | output | 2*BYTE_W (16) | New pair value, new memory word, or compare difference |
| writeYa | output | 1 | Result is to be written to the pair |
| writeMem | output | 1 | Result is to be written to the memory word |
| flagWe | output | 5 | Flag write mask {N,V,H,Z,C} |
| flagN | output | 1 | Negative flag value |
| flagV | output | 1 | Overflow flag value |
| flagH | output | 1 | Half-carry flag value |
| flagZ | output | 1 | Zero flag value |
| flagC | output | 1 | Carry flag value |

## Verification
The bench builds the unit with its default byte width of 8, so the word is 16 bits. This puts every corner within reach of directed values: carry and borrow crossing from the low byte into the high byte, the full-word wrap at 0xFFFF and 0x0000, signed overflow around 0x7FFF and 0x8000, and the bit-11 half-carry edge. At this width, subtracting zero and comparing equal words also show the no-borrow carry rule directly at the ports.

// File: rtl/pair_alu_pkg.sv
package pair_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_INC = 3'd3,
    OP_DEC = 3'd4
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HIGH = 1'b1
  } state_e;

  typedef struct packed {
    logic loadLow;
    logic finishHigh;
  } strobe_t;

  localparam int FLAG_N = 4;
  localparam int FLAG_V = 3;
  localparam int FLAG_H = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  localparam logic [4:0] WE_ALL  = 5'b11111;
  localparam logic [4:0] WE_NZC  = 5'b10011;
  localparam logic [4:0] WE_NZ   = 5'b10010;

endpackage

// File: rtl/pair_alu_ctrl.sv
module pair_alu_ctrl
  import pair_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] opSel,
  output strobe_t    strobes,
  output logic       busy,
  output logic       done
);

  state_e state;
  logic   opValid;

  assign opValid = (opSel <= 3'(OP_DEC));

  always_comb begin
    strobes.loadLow    = start && (state == ST_IDLE) && opValid;
    strobes.finishHigh = (state == ST_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobes.finishHigh;
      if (strobes.loadLow)
        state <= ST_HIGH;
      else if (strobes.finishHigh)
        state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_HIGH);

endmodule

// File: rtl/pair_alu_datapath.sv
module pair_alu_datapath
  import pair_alu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               strobes,
  input  logic [2:0]            opSel,
  input  logic [BYTE_W-1:0]     regY,
  input  logic [BYTE_W-1:0]     regA,
  input  logic [2*BYTE_W-1:0]   memWord,
  output logic [2*BYTE_W-1:0]   result,
  output logic                  writeYa,
  output logic                  writeMem,
  output logic [4:0]            flagWe,
  output logic [4:0]            flagVal
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int MSB    = BYTE_W - 1;

  op_e                opIn;
  logic [WORD_W-1:0]  xWord;
  logic [WORD_W-1:0]  bWord;
  logic               carryIn;
  logic [BYTE_W:0]    lowSum;

  op_e                opQ;
  logic [BYTE_W-1:0]  sumLoQ;
  logic               cLoQ;
  logic [BYTE_W-1:0]  xHiQ;
  logic [BYTE_W-1:0]  bHiQ;

  logic [BYTE_W:0]    hiSum;
  logic [WORD_W-1:0]  fullWord;
  logic               halfCarry;
  logic               ovf;

  assign opIn = op_e'(opSel);

  // Select the adder inputs for the low-byte step
  always_comb begin
    xWord   = {regY, regA};
    bWord   = memWord;
    carryIn = 1'b0;
    unique case (opIn)
      OP_ADD: begin
        bWord = memWord;
      end
      OP_SUB, OP_CMP: begin
        bWord   = ~memWord;
        carryIn = 1'b1;
      end
      OP_INC: begin
        xWord   = memWord;
        bWord   = '0;
        carryIn = 1'b1;
      end
      OP_DEC: begin
        xWord   = memWord;
        bWord   = '1;
      end
      default: begin
        bWord = memWord;
      end
    endcase
  end

  assign lowSum = {1'b0, xWord[BYTE_W-1:0]} + {1'b0, bWord[BYTE_W-1:0]}
                + {{BYTE_W{1'b0}}, carryIn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opQ    <= OP_ADD;
      sumLoQ <= '0;
      cLoQ   <= 1'b0;
      xHiQ   <= '0;
      bHiQ   <= '0;
    end else if (strobes.loadLow) begin
      opQ    <= opIn;
      sumLoQ <= lowSum[BYTE_W-1:0];
      cLoQ   <= lowSum[BYTE_W];
      xHiQ   <= xWord[WORD_W-1:BYTE_W];
      bHiQ   <= bWord[WORD_W-1:BYTE_W];
    end
  end

  // High-byte step using the stored low-byte carry
  assign hiSum     = {1'b0, xHiQ} + {1'b0, bHiQ} + {{BYTE_W{1'b0}}, cLoQ};
  assign fullWord  = {hiSum[BYTE_W-1:0], sumLoQ};
  assign halfCarry = hiSum[NIB_W] ^ xHiQ[NIB_W] ^ bHiQ[NIB_W];
  assign ovf       = (xHiQ[MSB] == bHiQ[MSB]) && (hiSum[MSB] != xHiQ[MSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result   <= '0;
      writeYa  <= 1'b0;
      writeMem <= 1'b0;
      flagWe   <= '0;
      flagVal  <= '0;
    end else if (strobes.finishHigh) begin
      result          <= fullWord;
      flagVal[FLAG_N] <= hiSum[MSB];
      flagVal[FLAG_V] <= ovf;
      flagVal[FLAG_H] <= halfCarry;
      flagVal[FLAG_Z] <= (fullWord == '0);
      flagVal[FLAG_C] <= hiSum[BYTE_W];
      unique case (opQ)
        OP_ADD, OP_SUB: begin
          writeYa  <= 1'b1;
          writeMem <= 1'b0;
          flagWe   <= WE_ALL;
        end
        OP_CMP: begin
          writeYa  <= 1'b0;
          writeMem <= 1'b0;
          flagWe   <= WE_NZC;
        end
        OP_INC, OP_DEC: begin
          writeYa  <= 1'b0;
          writeMem <= 1'b1;
          flagWe   <= WE_NZ;
        end
        default: begin
          writeYa  <= 1'b0;
          writeMem <= 1'b0;
          flagWe   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pair_word_alu.sv
module pair_word_alu
  import pair_alu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [2:0]            opSel,
  input  logic [BYTE_W-1:0]     regY,
  input  logic [BYTE_W-1:0]     regA,
  input  logic [2*BYTE_W-1:0]   memWord,
  output logic                  busy,
  output logic                  done,
  output logic [2*BYTE_W-1:0]   result,
  output logic                  writeYa,
  output logic                  writeMem,
  output logic [4:0]            flagWe,
  output logic                  flagN,
  output logic                  flagV,
  output logic                  flagH,
  output logic                  flagZ,
  output logic                  flagC
);

  strobe_t    strobes;
  logic [4:0] flagVal;

  pair_alu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opSel   (opSel),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  pair_alu_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .opSel    (opSel),
    .regY     (regY),
    .regA     (regA),
    .memWord  (memWord),
    .result   (result),
    .writeYa  (writeYa),
    .writeMem (writeMem),
    .flagWe   (flagWe),
    .flagVal  (flagVal)
  );

  assign flagN = flagVal[FLAG_N];
  assign flagV = flagVal[FLAG_V];
  assign flagH = flagVal[FLAG_H];
  assign flagZ = flagVal[FLAG_Z];
  assign flagC = flagVal[FLAG_C];

endmodule

// File: rtl/pair_word_alu_chk.sv
module pair_word_alu_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [2:0]          opSel,
  input logic                busy,
  input logic                done,
  input logic [2*BYTE_W-1:0] result,
  input logic                writeYa,
  input logic                writeMem,
  input logic [4:0]          flagWe,
  input logic                flagN,
  input logic                flagZ
);

  // R2
  busy_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done && !busy));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && opSel <= 3'd4) |=> busy);

  // R3
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && opSel > 3'd4) |=> !busy);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result != $past(result)) |-> done);

  // R8
  dest_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({writeYa, writeMem}));

  // R9
  mem_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && writeMem) |-> (flagWe == 5'b10010));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flagZ == (result == '0)));

  // R10
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flagN == result[2*BYTE_W-1]));

endmodule

bind pair_word_alu pair_word_alu_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .opSel    (opSel),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .writeYa  (writeYa),
  .writeMem (writeMem),
  .flagWe   (flagWe),
  .flagN    (flagN),
  .flagZ    (flagZ)
);

// File: tb/tb_pair_word_alu.sv
`timescale 1ns/1ps
module tb_pair_word_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [7:0]  regY = 8'd0;
  logic [7:0]  regA = 8'd0;
  logic [15:0] memWord = 16'd0;
  logic        busy, done, writeYa, writeMem;
  logic [15:0] result;
  logic [4:0]  flagWe;
  logic        flagN, flagV, flagH, flagZ, flagC;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pair_word_alu dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .regY(regY), .regA(regA), .memWord(memWord),
    .busy(busy), .done(done), .result(result),
    .writeYa(writeYa), .writeMem(writeMem), .flagWe(flagWe),
    .flagN(flagN), .flagV(flagV), .flagH(flagH), .flagZ(flagZ), .flagC(flagC)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Full operation with expected values from the requirements
  task automatic runOp(input logic [2:0] op, input logic [7:0] y, input logic [7:0] a,
                       input logic [15:0] m, input string tag);
    logic [15:0] ya, exp;
    logic [16:0] full;
    logic [12:0] nib;
    logic        c, v, h, toYa, toMem;
    logic [4:0]  we;
    ya = {y, a};
    c = 0; v = 0; h = 0; toYa = 0; toMem = 0; we = 0; exp = 0;
    case (op)
      3'd0: begin
        full = {1'b0, ya} + {1'b0, m};
        exp = full[15:0]; c = full[16];
        v = (ya[15] == m[15]) && (exp[15] != ya[15]);
        nib = {1'b0, ya[11:0]} + {1'b0, m[11:0]}; h = nib[12];
        we = 5'b11111; toYa = 1;
      end
      3'd1, 3'd2: begin
        exp = ya - m; c = (ya >= m);
        v = (ya[15] != m[15]) && (exp[15] != ya[15]);
        nib = {1'b0, ya[11:0]} + {1'b0, ~m[11:0]} + 13'd1; h = nib[12];
        we = (op == 3'd1) ? 5'b11111 : 5'b10011; toYa = (op == 3'd1);
      end
      3'd3: begin exp = m + 16'd1; we = 5'b10010; toMem = 1; end
      default: begin exp = m - 16'd1; we = 5'b10010; toMem = 1; end
    endcase
    @(negedge clk);
    start = 1; opSel = op; regY = y; regA = a; memWord = m;
    @(negedge clk);
    start = 0;
    check({tag, " R2 busy"}, busy, 1);
    check({tag, " R2 no early done"}, done, 0);
    @(negedge clk);
    check({tag, " R2 done"}, done, 1);
    check({tag, " R2 busy low"}, busy, 0);
    check({tag, " R4/R5/R9 result"}, result, exp);
    check({tag, " R4/R8/R9 flagWe"}, flagWe, we);
    check({tag, " R8 writeYa"}, writeYa, toYa);
    check({tag, " R9 writeMem"}, writeMem, toMem);
    check({tag, " R10 N"}, flagN, exp[15]);
    check({tag, " R10 Z"}, flagZ, (exp == 16'd0));
    if (we[0]) check({tag, " R4/R5 C"}, flagC, c);
    if (we[3]) check({tag, " R6 V"}, flagV, v);
    if (we[2]) check({tag, " R7 H"}, flagH, h);
  endtask

  task automatic testReset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 result", result, 0);
    check("R1 writes", {writeYa, writeMem}, 0);
    check("R1 flagWe", flagWe, 0);
    check("R1 flags", {flagN, flagV, flagH, flagZ, flagC}, 0);
  endtask

  task automatic testAdd();
    runOp(3'd0, 8'h12, 8'h34, 16'h0101, "add plain");
    runOp(3'd0, 8'h00, 8'hFF, 16'h0001, "add low carry");
    runOp(3'd0, 8'hFF, 8'hFF, 16'h0001, "add wrap zero");
    runOp(3'd0, 8'h7F, 8'hFF, 16'h0001, "add overflow");
    runOp(3'd0, 8'h0F, 8'h00, 16'h0100, "add half carry R7");
  endtask

  task automatic testSub();
    runOp(3'd1, 8'h12, 8'h34, 16'h1234, "sub equal");
    runOp(3'd1, 8'h00, 8'h00, 16'h0001, "sub borrow");
    runOp(3'd1, 8'h56, 8'h78, 16'h0000, "sub zero operand");
    runOp(3'd1, 8'h80, 8'h00, 16'h0001, "sub overflow R6");
    runOp(3'd1, 8'h00, 8'h00, 16'h8000, "sub min operand R6");
    runOp(3'd1, 8'h10, 8'h00, 16'h0001, "sub half borrow R7");
  endtask

  task automatic testCmp();
    runOp(3'd2, 8'h40, 8'h00, 16'h4000, "cmp equal R8");
    runOp(3'd2, 8'h01, 8'h00, 16'h0200, "cmp less R8");
    runOp(3'd2, 8'hFF, 8'h00, 16'h0001, "cmp greater R8");
  endtask

  task automatic testIncDec();
    runOp(3'd3, 8'h00, 8'h00, 16'h00FF, "inc carry R9");
    runOp(3'd3, 8'h00, 8'h00, 16'hFFFF, "inc wrap R9");
    runOp(3'd4, 8'h00, 8'h00, 16'h0100, "dec borrow R9");
    runOp(3'd4, 8'h00, 8'h00, 16'h0000, "dec wrap R9");
    runOp(3'd4, 8'h00, 8'h00, 16'h0001, "dec to zero R9");
  endtask

  task automatic testHold();
    logic [15:0] keep;
    keep = result;
    @(negedge clk);
    check("R2 done single", done, 0);
    check("R2 result held", result, keep);
  endtask

  task automatic testBusyIgnore();
    @(negedge clk);
    start = 1; opSel = 3'd0; regY = 8'h01; regA = 8'h00; memWord = 16'h0002;
    @(negedge clk);
    // second request while busy: increment of 0x7000
    start = 1; opSel = 3'd3; memWord = 16'h7000;
    @(negedge clk);
    start = 0;
    check("R3 busy restart ignored busy", busy, 0);
    check("R3 busy restart first result", result, 16'h0102);
    check("R3 busy restart writeYa", writeYa, 1);
    @(negedge clk);
    check("R3 busy restart no second done", done, 0);
    check("R3 busy restart result kept", result, 16'h0102);
  endtask

  task automatic testReserved();
    logic [15:0] keep;
    logic [4:0]  keepWe;
    for (int code = 5; code < 8; code++) begin
      keep = result; keepWe = flagWe;
      @(negedge clk);
      start = 1; opSel = 3'(code); memWord = 16'hABCD;
      @(negedge clk);
      start = 0;
      check("R3 reserved no busy", busy, 0);
      @(negedge clk);
      check("R3 reserved no done", done, 0);
      check("R3 reserved result", result, keep);
      check("R3 reserved flagWe", flagWe, keepWe);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    @(negedge clk);
    testReset();
    testAdd();
    testHold();
    testSub();
    testCmp();
    testIncDec();
    testBusyIgnore();
    testReserved();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule